// File: doc/BRIEF.md
# Clock-Chip Readout Sequencer

This controller brings up an external calendar clock chip and reads its time over a nibble-wide serial link. It does not shift bits itself. It asks a separate serial master for one register transaction at a time and drives the chip-enable line between transactions. A free-running microsecond tick sets the spacing between busy polls.

An init request first checks the chip's oscillator-stop flag. When the flag is clear, the stored time is marked trustworthy. When it is set, the time is marked untrustworthy and the chip is reset and adjusted, with bounded busy polling. A read request confirms with a bounded busy handshake that the chip is free. It then fetches every calendar field as a ones nibble followed by a tens nibble and converts each pair to binary. A pivot rule widens the two-digit year to four digits. A one-cycle done pulse ends every sequence. The valid and error flags hold their values until the next accepted request.

Top module: `rtc_readout_seq`

## Requirements
- R1: After reset, chip_en, xfer_req, done, valid and error are all 0.
- R2: An init request drives chip_en low for one cycle and then high, and reads the control register (default address 14). When the stop bit (default bit 1) reads 0, valid becomes 1, error becomes 0, and no further transaction follows.
- R3: When the stop bit reads 1, valid becomes 0. The block then writes 0 to the timer-interrupt register (default address 7), and then writes the control base value OR the adjust bit (default 4'b1000 | bit 0 = 9) to the control register.
- R4: After the adjust write, the control register is read at most 1000 times, and consecutive reads are separated by at least one us_tick. The first read whose busy bit (default bit 0) is 0 is followed by a write of the base value (8) to the control register, with error 0. If all 1000 reads show busy, error is set and no base write is made.
- R5: A read request while valid is 0 sets error and finishes with a done pulse, without any transaction and without raising chip_en.
- R6: A read request makes up to 10 tries. Each try raises chip_en, writes the base value to the control register and reads the control register. When busy is set, chip_en drops and the block waits for a us_tick before the next try. If all 10 tries show busy, error is set and valid is left unchanged.
- R7: After a successful handshake, the field registers are read in this order: seconds (ones 0, tens 1), minutes (2, 3), hours (4, 5), day (8, 9), month (10, 11), year (12, 13). Each field's ones nibble comes before its tens nibble. Each field output is tens*10+ones, computed for any nibble value 0 to 15.
- R8: The year output is (two-digit value mod 100) + 1900, plus 100 when that sum is below 1970. The result always lies in 1970 to 2069.
- R9: The weekday register (address 6) is read last, and its nibble appears unchanged on wday.
- R10: chip_en is 0 when done pulses, on error exits as well. done is high for exactly one cycle.
- R11: If init_req and read_req arrive in the same idle cycle, only the init sequence runs. Any request that arrives while a sequence is running is ignored.
- R12: xfer_req stays high, with address, direction and write data unchanged, until xfer_done. chip_en is 1 throughout every transaction.
- R13: valid and error do not change while the block is idle and no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_req | input | 1 | Start the bring-up sequence |
| read_req | input | 1 | Start a calendar read |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| xfer_req | output | 1 | Transaction request to the serial master |
| xfer_write | output | 1 | 1 = register write, 0 = register read |
| xfer_addr | output | 4 | Chip register address |
| xfer_wdata | output | 4 | Nibble to write |
| xfer_done | input | 1 | Serial master has finished the transaction |
| xfer_rdata | input | 4 | Nibble read, valid with xfer_done |
| chip_en | output | 1 | Chip-enable to the clock chip |
| done | output | 1 | One-cycle end-of-sequence pulse |
| valid | output | 1 | Stored chip time is trustworthy |
| error | output | 1 | Last sequence failed |
| sec | output | 8 | Seconds, binary |
| min | output | 8 | Minutes, binary |
| hour | output | 8 | Hours, binary |
| day | output | 8 | Day of month, binary |
| mon | output | 8 | Month, binary |
| year | output | 12 | Four-digit year |
| wday | output | 4 | Weekday nibble |

## Verification
Two pairs of functions can meet in one cycle. The first pair is the two request inputs. The bench raises init_req and read_req on the same idle edge and requires exactly one control-register read and the init outcome, with no handshake writes. The second pair is a running sequence and a new request. The bench pulses init_req in the middle of a busy-retrying read. It then checks that the transaction stream still matches the read alone, and that the number of chip-enable rises equals the number of tries.

// File: rtl/rtcs_pkg.sv
// Shared types for the clock-chip readout sequencer.
// Assumes: one state register of at most 16 states.
package rtcs_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_I_CEOFF,
        S_I_RDCTL,
        S_I_WTINT,
        S_I_WADJ,
        S_I_POLL,
        S_I_PWAIT,
        S_I_WBASE,
        S_R_CEON,
        S_R_WBASE,
        S_R_RDCTL,
        S_R_WAIT,
        S_R_FIELD,
        S_FINISH
    } seq_state_t;
endpackage

// File: rtl/rtcs_try_counter.sv
// Attempt counter shared by the busy poll and the read handshake.
// Assumes: the owner never asks for an increment past its own limit.
module rtcs_try_counter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    // count attempts; clear has priority over increment
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rtcs_digit_join.sv
// Joins a ones nibble and a tens nibble into a binary value tens*10+ones.
// Assumes: nibbles may exceed 9; the result is at most 165.
module rtcs_digit_join (
    input  logic [3:0] ones,
    input  logic [3:0] tens,
    output logic [7:0] value
);
    // tens*10 as tens*8 + tens*2, then add the ones nibble
    always_comb value = {1'b0, tens, 3'b000} + {3'b000, tens, 1'b0} + {4'b0000, ones};
endmodule

// File: rtl/rtcs_year_window.sv
// Widens a two-digit year (0..165) to four digits inside a 100-year window.
// Assumes: the input comes from rtcs_digit_join.
module rtcs_year_window #(
    parameter int CENTURY = 1900,
    parameter int PIVOT   = 1970
) (
    input  logic [7:0]  yy,
    output logic [11:0] year
);
    logic [7:0] yy_mod;
    int         full;
    // reduce modulo 100, add the century, then shift up when below the pivot
    always_comb begin
        yy_mod = (yy >= 8'd100) ? yy - 8'd100 : yy;
        full   = CENTURY + int'(yy_mod);
        if (full < PIVOT) full = full + 100;
        year   = full[11:0];
    end
endmodule

// File: rtl/rtc_readout_seq.sv
// Clock-chip readout and validity sequencer.
// It asks a serial master for nibble register transactions and drives
// chip-enable. On init it checks the stop flag and, when needed, runs the
// reset-and-adjust sequence with busy polling. On read it performs a bounded
// busy handshake and then fetches and converts the calendar fields.
// Assumes: xfer_done is raised only while xfer_req is high; us_tick is a
// one-cycle pulse.
module rtc_readout_seq
    import rtcs_pkg::*;
#(
    parameter int               POLL_LIMIT  = 1000,
    parameter int               RETRY_LIMIT = 10,
    parameter logic [3:0]       ADDR_CTRL   = 4'd14,
    parameter logic [3:0]       ADDR_TINT   = 4'd7,
    parameter logic [3:0]       CTRL_BASE   = 4'b1000,
    parameter int               BUSY_BIT    = 0,
    parameter int               ADJ_BIT     = 0,
    parameter int               STOP_BIT    = 1,
    parameter logic [12:0][3:0] FIELD_ADDRS = {4'd6, 4'd13, 4'd12, 4'd11, 4'd10, 4'd9,
                                               4'd8, 4'd5, 4'd4, 4'd3, 4'd2, 4'd1, 4'd0}
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_req,
    input  logic        read_req,
    input  logic        us_tick,
    output logic        xfer_req,
    output logic        xfer_write,
    output logic [3:0]  xfer_addr,
    output logic [3:0]  xfer_wdata,
    input  logic        xfer_done,
    input  logic [3:0]  xfer_rdata,
    output logic        chip_en,
    output logic        done,
    output logic        valid,
    output logic        error,
    output logic [7:0]  sec,
    output logic [7:0]  min,
    output logic [7:0]  hour,
    output logic [7:0]  day,
    output logic [7:0]  mon,
    output logic [11:0] year,
    output logic [3:0]  wday
);
    localparam int         NREADS  = 13;
    localparam int         MAXTRY  = (POLL_LIMIT > RETRY_LIMIT) ? POLL_LIMIT : RETRY_LIMIT;
    localparam int         CW      = $clog2(MAXTRY) + 1;
    localparam logic [3:0] CTRL_ADJ = CTRL_BASE | (4'b0001 << ADJ_BIT);

    seq_state_t      state;
    logic [3:0]      idx;
    logic [3:0]      ones_q;
    logic [5:0][7:0] fld_q;
    logic [7:0]      joined;
    logic [CW-1:0]   cnt;
    logic            cnt_clr, cnt_inc, at_limit, busy_seen, stop_seen;

    rtcs_try_counter #(.W(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
    );

    rtcs_digit_join u_join (.ones(ones_q), .tens(xfer_rdata), .value(joined));

    rtcs_year_window u_year (.yy(fld_q[5]), .year(year));

    // status bits of the control nibble being returned
    always_comb begin
        busy_seen = xfer_rdata[BUSY_BIT];
        stop_seen = xfer_rdata[STOP_BIT];
    end

    // attempt-limit selection and counter control
    always_comb begin
        at_limit = (state == S_I_POLL) ? (int'(cnt) == POLL_LIMIT - 1)
                                       : (int'(cnt) == RETRY_LIMIT - 1);
        cnt_clr  = (state == S_IDLE);
        cnt_inc  = xfer_done && busy_seen && !at_limit &&
                   (state == S_I_POLL || state == S_R_RDCTL);
    end

    // transaction request decoded from the current state
    always_comb begin
        xfer_req   = 1'b0;
        xfer_write = 1'b0;
        xfer_addr  = ADDR_CTRL;
        xfer_wdata = 4'd0;
        case (state)
            S_I_RDCTL, S_I_POLL, S_R_RDCTL: xfer_req = 1'b1;
            S_I_WTINT: begin
                xfer_req = 1'b1; xfer_write = 1'b1; xfer_addr = ADDR_TINT;
            end
            S_I_WADJ: begin
                xfer_req = 1'b1; xfer_write = 1'b1; xfer_wdata = CTRL_ADJ;
            end
            S_I_WBASE, S_R_WBASE: begin
                xfer_req = 1'b1; xfer_write = 1'b1; xfer_wdata = CTRL_BASE;
            end
            S_R_FIELD: begin
                xfer_req = 1'b1; xfer_addr = FIELD_ADDRS[idx];
            end
            default: ;
        endcase
    end

    // sequence control, flags, chip-enable and field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            chip_en <= 1'b0;
            done    <= 1'b0;
            valid   <= 1'b0;
            error   <= 1'b0;
            idx     <= '0;
            ones_q  <= '0;
            fld_q   <= '0;
            wday    <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (init_req) begin
                        chip_en <= 1'b0;
                        error   <= 1'b0;
                        state   <= S_I_CEOFF;
                    end else if (read_req) begin
                        if (!valid) begin
                            error <= 1'b1;
                            state <= S_FINISH;
                        end else begin
                            error <= 1'b0;
                            state <= S_R_CEON;
                        end
                    end
                end
                S_I_CEOFF: begin
                    chip_en <= 1'b1;
                    state   <= S_I_RDCTL;
                end
                S_I_RDCTL: if (xfer_done) begin
                    if (!stop_seen) begin
                        valid <= 1'b1;
                        state <= S_FINISH;
                    end else begin
                        valid <= 1'b0;
                        state <= S_I_WTINT;
                    end
                end
                S_I_WTINT: if (xfer_done) state <= S_I_WADJ;
                S_I_WADJ:  if (xfer_done) state <= S_I_POLL;
                S_I_POLL: if (xfer_done) begin
                    if (!busy_seen)    state <= S_I_WBASE;
                    else if (at_limit) begin
                        error <= 1'b1;
                        state <= S_FINISH;
                    end else           state <= S_I_PWAIT;
                end
                S_I_PWAIT: if (us_tick) state <= S_I_POLL;
                S_I_WBASE: if (xfer_done) state <= S_FINISH;
                S_R_CEON: begin
                    chip_en <= 1'b1;
                    state   <= S_R_WBASE;
                end
                S_R_WBASE: if (xfer_done) state <= S_R_RDCTL;
                S_R_RDCTL: if (xfer_done) begin
                    if (!busy_seen) begin
                        idx   <= '0;
                        state <= S_R_FIELD;
                    end else begin
                        chip_en <= 1'b0;
                        if (at_limit) begin
                            error <= 1'b1;
                            state <= S_FINISH;
                        end else state <= S_R_WAIT;
                    end
                end
                S_R_WAIT: if (us_tick) state <= S_R_CEON;
                S_R_FIELD: if (xfer_done) begin
                    if (int'(idx) == NREADS - 1) begin
                        wday  <= xfer_rdata;
                        state <= S_FINISH;
                    end else begin
                        if (!idx[0]) ones_q <= xfer_rdata;
                        else         fld_q[idx[3:1]] <= joined;
                        idx <= idx + 1'b1;
                    end
                end
                S_FINISH: begin
                    chip_en <= 1'b0;
                    done    <= 1'b1;
                    state   <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign sec  = fld_q[0];
    assign min  = fld_q[1];
    assign hour = fld_q[2];
    assign day  = fld_q[3];
    assign mon  = fld_q[4];

    AST_INVALID_READ_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && read_req && !init_req && !valid) |=> (error && !xfer_req && !chip_en)); // R5
    AST_CE_LOW_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !chip_en); // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_CE_DURING_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> chip_en); // R12
    AST_XFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_write) && $stable(xfer_wdata))); // R12
    AST_FLAGS_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !init_req && !read_req) |=> ($stable(valid) && $stable(error))); // R13
    AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < MAXTRY); // R4
endmodule

// File: tb/sim_rtc_readout_seq.sv
// Bench: behavioural chip model and serial-master responder, with an
// expected-transaction queue compared on every transaction and a set of
// per-clock rules checked on every cycle.
module sim_rtc_readout_seq;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, init_req, read_req, us_tick;
    logic        xfer_req, xfer_write, xfer_done;
    logic [3:0]  xfer_addr, xfer_wdata, xfer_rdata, wday;
    logic        chip_en, done, valid, error;
    logic [7:0]  sec, min, hour, day, mon;
    logic [11:0] year;

    rtc_readout_seq u0 (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .read_req(read_req),
        .us_tick(us_tick), .xfer_req(xfer_req), .xfer_write(xfer_write),
        .xfer_addr(xfer_addr), .xfer_wdata(xfer_wdata), .xfer_done(xfer_done),
        .xfer_rdata(xfer_rdata), .chip_en(chip_en), .done(done), .valid(valid),
        .error(error), .sec(sec), .min(min), .hour(hour), .day(day), .mon(mon),
        .year(year), .wday(wday)
    );

    typedef struct { bit w; logic [3:0] a; logic [3:0] d; string tag; } txn_t;
    txn_t       expq[$];
    logic [3:0] regs [16];
    int         busy_left = 0;
    bit         stop_flag = 0;
    int         vectors = 0, miscompares = 0, cycles = 0, ce_rises = 0, tick_cnt = 0;
    bit         ce_prev = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push(bit w, int a, int d, string tag);
        txn_t t;
        t.w = w; t.a = 4'(a); t.d = 4'(d); t.tag = tag;
        expq.push_back(t);
    endtask

    task automatic exp_tries(int n);
        for (int i = 0; i < n; i++) begin
            push(1, 14, 8, "R6 handshake base write");
            push(0, 14, 0, "R6 handshake control read");
        end
    endtask

    task automatic exp_fields();
        int order [13] = '{0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 12, 13, 6};
        for (int i = 0; i < 13; i++) push(0, order[i], 0, (i == 12) ? "R9 weekday read" : "R7 field read");
    endtask

    task automatic set_pair(int a, int ones, int tens);
        regs[a] = 4'(ones); regs[a+1] = 4'(tens);
    endtask

    // microsecond tick every five cycles
    always @(negedge clk) begin
        tick_cnt = (tick_cnt == 4) ? 0 : tick_cnt + 1;
        us_tick  = (tick_cnt == 0);
    end

    // per-clock rules, chip-enable rise counting and watchdog
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            chk(!xfer_req || chip_en, "R12 chip_en during transfer", chip_en, 1);
            chk(!done || !chip_en, "R10 chip_en low at done", chip_en, 0);
            if (chip_en && !ce_prev) ce_rises++;
        end
        ce_prev = chip_en;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // serial-master responder with chip model
    initial begin
        xfer_done = 0; xfer_rdata = 0;
        forever begin
            @(negedge clk);
            if (rst_n && xfer_req) begin
                logic [3:0] rd;
                rd = 0;
                if (expq.size() == 0)
                    chk(0, "R11 unexpected transaction", {xfer_write, xfer_addr, xfer_wdata}, 0);
                else begin
                    txn_t t;
                    t = expq.pop_front();
                    chk(xfer_write == t.w && xfer_addr == t.a && (!t.w || xfer_wdata == t.d), t.tag,
                        {xfer_write, xfer_addr, xfer_wdata}, {t.w, t.a, t.w ? t.d : xfer_wdata});
                end
                if (!xfer_write && xfer_addr == 4'd14) begin
                    rd = {2'b00, stop_flag, busy_left > 0};
                    if (busy_left > 0) busy_left--;
                end else if (!xfer_write) rd = regs[xfer_addr];
                repeat (2) @(negedge clk);
                xfer_rdata = rd; xfer_done = 1;
                @(negedge clk);
                xfer_done = 0;
            end
        end
    end

    task automatic run(bit do_init, bit do_read, bit mid_init, bit exp_valid, bit exp_error,
                       int exp_rises, string tag);
        ce_rises = 0;
        @(negedge clk);
        init_req = do_init; read_req = do_read;
        @(negedge clk);
        init_req = 0; read_req = 0;
        if (mid_init) begin
            repeat (6) @(negedge clk);
            init_req = 1;
            @(negedge clk);
            init_req = 0;
        end
        while (!done) @(negedge clk);
        chk(valid == exp_valid, {tag, " valid"}, valid, exp_valid);
        chk(error == exp_error, {tag, " error"}, error, exp_error);
        chk(ce_rises == exp_rises, {tag, " chip_en rises"}, ce_rises, exp_rises);
        chk(expq.size() == 0, {tag, " transactions missing"}, expq.size(), 0);
        expq.delete();
        repeat (5) @(negedge clk);
        chk(valid == exp_valid && error == exp_error, "R13 flags held while idle",
            {valid, error}, {exp_valid, exp_error});
        chk(!xfer_req && !chip_en, "R10 idle after sequence", {xfer_req, chip_en}, 0);
    endtask

    initial begin
        rst_n = 0; init_req = 0; read_req = 0;
        for (int i = 0; i < 16; i++) regs[i] = 0;
        repeat (3) @(negedge clk);
        chk(!chip_en && !xfer_req && !done && !valid && !error, "R1 reset state",
            {chip_en, xfer_req, done, valid, error}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(!chip_en && !xfer_req && !done && !valid && !error, "R1 after reset release",
            {chip_en, xfer_req, done, valid, error}, 0);

        // read before any init: no chip access
        run(0, 1, 0, 0, 1, 0, "R5 read while invalid");

        // init with oscillator running
        stop_flag = 0; busy_left = 0;
        push(0, 14, 0, "R2 stop check read");
        run(1, 0, 0, 1, 0, 1, "R2 init clean");

        // read with no busy: 59:07:23, day 31, month 12, year 69, weekday 6
        set_pair(0, 9, 5); set_pair(2, 7, 0); set_pair(4, 3, 2);
        set_pair(8, 1, 3); set_pair(10, 2, 1); set_pair(12, 9, 6); regs[6] = 4'd6;
        busy_left = 0;
        exp_tries(1); exp_fields();
        run(0, 1, 0, 1, 0, 1, "R7 read plain");
        chk(sec == 59 && min == 7 && hour == 23, "R7 sec/min/hour", {sec, min, hour}, {8'd59, 8'd7, 8'd23});
        chk(day == 31 && mon == 12, "R7 day/mon", {day, mon}, {8'd31, 8'd12});
        chk(year == 2069, "R8 year 69", year, 2069);
        chk(wday == 6, "R9 weekday", wday, 6);

        // busy three times, year 70
        set_pair(12, 0, 7); busy_left = 3;
        exp_tries(4); exp_fields();
        run(0, 1, 0, 1, 0, 4, "R6 three busy tries");
        chk(year == 1970, "R8 year 70", year, 1970);

        // busy nine times, year 00, nibbles at 15
        set_pair(12, 0, 0); set_pair(0, 15, 15); busy_left = 9;
        exp_tries(10); exp_fields();
        run(0, 1, 0, 1, 0, 10, "R6 nine busy tries");
        chk(year == 2000, "R8 year 00", year, 2000);
        chk(sec == 165, "R7 nibbles above nine", sec, 165);

        // year nibbles at 15: 165 mod 100 = 65 -> 1965 -> 2065
        set_pair(12, 15, 15); busy_left = 0;
        exp_tries(1); exp_fields();
        run(0, 1, 0, 1, 0, 1, "R7 read year 165");
        chk(year == 2065, "R8 year 165", year, 2065);

        // handshake exhausted: error, valid kept
        busy_left = 10;
        exp_tries(10);
        run(0, 1, 0, 1, 1, 10, "R6 retries exhausted");

        // init and read requested together
        stop_flag = 0; busy_left = 0;
        push(0, 14, 0, "R11 init wins");
        run(1, 1, 0, 1, 0, 1, "R11 simultaneous requests");

        // request during a running read is ignored
        busy_left = 3;
        exp_tries(4); exp_fields();
        run(0, 1, 1, 1, 0, 4, "R11 request while busy");

        // stop flag set, five busy polls then clear
        stop_flag = 1; busy_left = 6;
        push(0, 14, 0, "R2 stop check read");
        push(1, 7, 0, "R3 timer-interrupt clear");
        push(1, 14, 9, "R3 adjust write");
        for (int i = 0; i < 6; i++) push(0, 14, 0, "R4 busy poll");
        push(1, 14, 8, "R4 base write");
        run(1, 0, 0, 0, 0, 1, "R3 adjust sequence");

        // read after the adjust sequence: time still invalid
        run(0, 1, 0, 0, 1, 0, "R5 read after adjust");

        // poll exhausted after 1000 busy reads
        stop_flag = 1; busy_left = 5000;
        push(0, 14, 0, "R2 stop check read");
        push(1, 7, 0, "R3 timer-interrupt clear");
        push(1, 14, 9, "R3 adjust write");
        for (int i = 0; i < 1000; i++) push(0, 14, 0, "R4 busy poll");
        run(1, 0, 0, 0, 1, 1, "R4 poll exhausted");

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule